// File: doc/BRIEF.md
# GPIO Pin Interrupt Sense Unit

This unit watches a bank of general-purpose pins and turns their activity into two interrupt requests, A and B. Each pin has its own configuration bits. One bit says whether the pin is an output. Another enables its input path. Two more choose edge or level sensing, and one or both edges. A polarity bit has a meaning that depends on the mode. Every pin goes through a synchronizer chain. The unit then keeps the last level it accepted from each enabled input, and it exposes those levels as the input bits of the port data word.

Each pin has a four-state machine that decides its pending-interrupt bit:

- `PS_OFF`: the pin is an output or its input is disabled.
- `PS_WATCH`: the pin is enabled and nothing is pending.
- `PS_PULSE`: an edge event is pending for one cycle.
- `PS_HOLD`: a level condition is active.

The machine takes these transitions on each clock:

- Any state goes to `PS_OFF` when the pin is disabled.
- An enabled pin in edge mode goes to `PS_PULSE` when the edge rule is met, and to `PS_WATCH` otherwise.
- An enabled pin in level mode goes to `PS_HOLD` while its level differs from the polarity bit, and to `PS_WATCH` once the two are equal.

The pending bits go through two masks, and each masked set is ORed into a registered request. Changing a mask alone updates the request on the next clock.

Top module: `gpio_irq_sense`

## Requirements
- R1: A pin whose direction bit is 1 (output) or whose input-enable bit is 0 is ignored: its bit of `data_o` keeps its value and its pending bit is 0 from the next clock on.
- R2: For an enabled input, the pin level appears in its bit of `data_o` three rising edges after it is applied: two synchronizer stages plus the data register.
- R3: In edge mode with the both-edges bit at 1, any change of the accepted level sets the pin's pending bit, and an unchanged level never sets it.
- R4: In edge mode with the both-edges bit at 0, polarity 0 detects a rise (0 to 1) only and polarity 1 detects a fall (1 to 0) only.
- R5: An edge event holds the pending bit for exactly one cycle.
- R6: In level mode the pending bit is 1 while the accepted level differs from the polarity bit and 0 as soon as the two are equal.
- R7: `irq_a_o` is the OR of (pending AND `mask_a_i`) registered one cycle, and `irq_b_o` is the same with `mask_b_i`.
- R8: A change of a mask alone updates its request on the next rising edge, with no pin activity.
- R9: Setting a pin to output, or clearing its input enable, clears its pending bit on the next clock, even while a level condition is active.
- R10: After reset, `data_o`, `pend_o`, `irq_a_o` and `irq_b_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | NPINS | Asynchronous pin levels |
| cfg_dir_i | input | NPINS | 1 = pin is an output |
| cfg_inen_i | input | NPINS | 1 = input path enabled |
| cfg_edge_i | input | NPINS | 1 = edge sensing, 0 = level sensing |
| cfg_both_i | input | NPINS | 1 = both edges (edge mode only) |
| cfg_polar_i | input | NPINS | Edge mode: 0 rise / 1 fall; level mode: active level is the inverse of this bit |
| mask_a_i | input | NPINS | Pins routed to request A |
| mask_b_i | input | NPINS | Pins routed to request B |
| data_o | output | NPINS | Accepted input levels (input bits of the data word) |
| pend_o | output | NPINS | Pending-interrupt state per pin |
| irq_a_o | output | 1 | Request A |
| irq_b_o | output | 1 | Request B |

## Verification
Directed steps apply single rising and falling transitions to pins in each mode. The responses show the following:

- Rise and fall detection under each polarity give different results, which separates the two single-edge polarities from both-edge sensing.
- A single-cycle pulse is distinguishable from a held level request.
- Mask-only changes show that the requests are re-evaluated without any pin activity.
- Disabling a pin while its level condition is active shows that the pending bit is cleared.
- Changing a disabled pin shows that its data bit is frozen.

A long phase then drives random pin values every cycle and random configuration and masks every few dozen cycles. This exposes interactions between mode switches and stale stored levels. A behavioural reference model compares every output on every cycle.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;
    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_WATCH = 2'd1,
        PS_PULSE = 2'd2,
        PS_HOLD  = 2'd3
    } pin_state_e;
endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gpio_pin_fsm.sv
module gpio_pin_fsm
    import gpio_sense_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic lvl_now_i,
    input  logic lvl_prev_i,
    input  logic edge_md_i,
    input  logic both_i,
    input  logic polar_i,
    output logic pend_o
);
    pin_state_e st_q, st_d, eval_st;
    logic       hit, active;

    // edge rule and level rule for this pin
    always_comb begin
        if (both_i) hit = lvl_now_i ^ lvl_prev_i;
        else if (polar_i) hit = lvl_prev_i & ~lvl_now_i;
        else hit = ~lvl_prev_i & lvl_now_i;
        active = lvl_now_i ^ polar_i;
        if (edge_md_i) eval_st = hit ? PS_PULSE : PS_WATCH;
        else           eval_st = active ? PS_HOLD : PS_WATCH;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PS_OFF:   st_d = en_i ? eval_st : PS_OFF;
            PS_WATCH: st_d = en_i ? eval_st : PS_OFF;
            PS_PULSE: st_d = en_i ? eval_st : PS_OFF;
            PS_HOLD:  st_d = en_i ? eval_st : PS_OFF;
            default:  st_d = PS_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PS_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            PS_PULSE, PS_HOLD: pend_o = 1'b1;
            default:           pend_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pend_i,
    input  logic [W-1:0] mask_a_i,
    input  logic [W-1:0] mask_b_i,
    output logic         irq_a_o,
    output logic         irq_b_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_a_o <= 1'b0;
            irq_b_o <= 1'b0;
        end else begin
            irq_a_o <= |(pend_i & mask_a_i);
            irq_b_o <= |(pend_i & mask_b_i);
        end
    end
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
    parameter int NPINS     = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    input  logic [NPINS-1:0] cfg_dir_i,
    input  logic [NPINS-1:0] cfg_inen_i,
    input  logic [NPINS-1:0] cfg_edge_i,
    input  logic [NPINS-1:0] cfg_both_i,
    input  logic [NPINS-1:0] cfg_polar_i,
    input  logic [NPINS-1:0] mask_a_i,
    input  logic [NPINS-1:0] mask_b_i,
    output logic [NPINS-1:0] data_o,
    output logic [NPINS-1:0] pend_o,
    output logic             irq_a_o,
    output logic             irq_b_o
);
    localparam int LAT = SYNC_DEPTH + 1;

    logic [NPINS-1:0] lvl_s;
    logic [NPINS-1:0] en;
    logic [NPINS-1:0] data_q;

    gpio_sync_chain #(.W(NPINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(lvl_s)
    );

    assign en = ~cfg_dir_i & cfg_inen_i;

    // only enabled inputs update their data bit
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= (data_q & ~en) | (lvl_s & en);
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        gpio_pin_fsm u_fsm (
            .clk(clk), .rst_n(rst_n), .en_i(en[p]),
            .lvl_now_i(lvl_s[p]), .lvl_prev_i(data_q[p]),
            .edge_md_i(cfg_edge_i[p]), .both_i(cfg_both_i[p]),
            .polar_i(cfg_polar_i[p]), .pend_o(pend_o[p])
        );
    end

    gpio_irq_merge #(.W(NPINS)) u_merge (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_o),
        .mask_a_i(mask_a_i), .mask_b_i(mask_b_i),
        .irq_a_o(irq_a_o), .irq_b_o(irq_b_o)
    );

    assign data_o = data_q;

    initial begin
        if (LAT < 2) $error("sync depth too small");
    end
endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk #(
    parameter int NPINS = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] cfg_dir_i,
    input logic [NPINS-1:0] cfg_inen_i,
    input logic [NPINS-1:0] cfg_edge_i,
    input logic [NPINS-1:0] cfg_polar_i,
    input logic [NPINS-1:0] mask_a_i,
    input logic [NPINS-1:0] mask_b_i,
    input logic [NPINS-1:0] data_o,
    input logic [NPINS-1:0] pend_o,
    input logic             irq_a_o,
    input logic             irq_b_o
);
    logic [NPINS-1:0] en_c;
    assign en_c = ~cfg_dir_i & cfg_inen_i;

    AST_IGNORED_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend_o & $past(~en_c)) == '0)); // R1

    AST_IGNORED_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((data_o ^ $past(data_o)) & $past(~en_c)) == '0)); // R1

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend_o & $past(en_c & cfg_edge_i) & ~(data_o ^ $past(data_o))) == '0)); // R3

    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((pend_o ^ data_o ^ $past(cfg_polar_i)) & $past(en_c & ~cfg_edge_i)) == '0)); // R6

    AST_IRQ_A_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_a_o == (|$past(pend_o & mask_a_i)))); // R7

    AST_IRQ_B_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_b_o == (|$past(pend_o & mask_b_i)))); // R7
endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_dir_i(cfg_dir_i), .cfg_inen_i(cfg_inen_i),
    .cfg_edge_i(cfg_edge_i), .cfg_polar_i(cfg_polar_i),
    .mask_a_i(mask_a_i), .mask_b_i(mask_b_i), .data_o(data_o),
    .pend_o(pend_o), .irq_a_o(irq_a_o), .irq_b_o(irq_b_o)
);

// File: tb/gpio_irq_sense_tb.sv
`timescale 1ns/1ps
module gpio_irq_sense_tb;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] pin = '0, dir = '0, inen = '0, edg = '0, both = '0, polar = '0;
    logic [N-1:0] mska = '0, mskb = '0;
    logic [N-1:0] data_o, pend_o;
    logic irq_a_o, irq_b_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_sense u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .cfg_dir_i(dir),
        .cfg_inen_i(inen), .cfg_edge_i(edg), .cfg_both_i(both),
        .cfg_polar_i(polar), .mask_a_i(mska), .mask_b_i(mskb),
        .data_o(data_o), .pend_o(pend_o), .irq_a_o(irq_a_o), .irq_b_o(irq_b_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [N-1:0] m_s1 = '0, m_s2 = '0, m_lvl = '0, m_pend = '0;
    logic m_irqa = 1'b0, m_irqb = 1'b0;

    always @(posedge clk) begin
        logic [N-1:0] np;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_lvl = '0; m_pend = '0;
            m_irqa = 1'b0; m_irqb = 1'b0;
        end else begin
            m_irqa = (m_pend & mska) != 0;
            m_irqb = (m_pend & mskb) != 0;
            np = '0;
            for (int i = 0; i < N; i++) begin
                if (!dir[i] && inen[i]) begin
                    if (edg[i]) begin
                        if (both[i]) np[i] = m_s2[i] != m_lvl[i];
                        else if (polar[i]) np[i] = m_lvl[i] && !m_s2[i];
                        else np[i] = !m_lvl[i] && m_s2[i];
                    end else begin
                        np[i] = m_s2[i] != polar[i];
                    end
                    m_lvl[i] = m_s2[i];
                end
            end
            m_pend = np;
            m_s2 = m_s1;
            m_s1 = pin;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 model data", data_o, m_lvl);
            chk("R6 model pend", pend_o, m_pend);
            chk("R7 model irq_a", irq_a_o, m_irqa);
            chk("R7 model irq_b", irq_b_o, m_irqb);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tick(4);
        chk("R10 data", data_o, 0);
        chk("R10 pend", pend_o, 0);
        chk("R10 irq", {irq_a_o, irq_b_o}, 0);
        rst_n = 1'b1;
        tick(1);
        // pins 0-3 both edges, 4-5 fall, 6-7 rise, 8-11 level active-low, 12-15 active-high
        inen = 16'hFFFF; edg = 16'h00FF; both = 16'h000F; polar = 16'h0F30;
        mska = 16'h00FF; mskb = 16'hFF00;
        tick(2);
        chk("R6 level low active", pend_o, 16'h0F00);
        chk("R7 irq_b up", irq_b_o, 1);
        chk("R7 irq_a idle", irq_a_o, 0);
        pin[5] = 1'b1;
        tick(3);
        chk("R4 fall-mode ignores rise", pend_o, 16'h0F00);
        chk("R2 data bit5", data_o[5], 1);
        pin[5] = 1'b0;
        tick(3);
        chk("R4 fall detected", pend_o, 16'h0F20);
        tick(1);
        chk("R5 pulse one cycle", pend_o, 16'h0F00);
        chk("R7 irq_a pulse", irq_a_o, 1);
        tick(1);
        chk("R7 irq_a back low", irq_a_o, 0);
        pin[2] = 1'b1; pin[6] = 1'b1;
        tick(3);
        chk("R3 R4 rises", pend_o, 16'h0F44);
        pin[2] = 1'b0;
        tick(3);
        chk("R3 fall on both", pend_o, 16'h0F04);
        tick(1);
        mskb = '0;
        tick(1);
        chk("R8 mask off", irq_b_o, 0);
        mskb = 16'h0100;
        tick(1);
        chk("R8 mask on", irq_b_o, 1);
        inen = 16'h00FF;
        tick(1);
        chk("R9 disable clears", pend_o, 0);
        pin[8] = 1'b1;
        tick(4);
        chk("R1 data frozen", data_o[8], 0);
        chk("R1 no pend", pend_o, 0);
        dir = 16'h0001; inen = 16'hFFFF;
        pin[0] = 1'b1;
        tick(4);
        chk("R1 output pin frozen", data_o[0], 0);
        for (int c = 0; c < 1500; c++) begin
            pin = N'($urandom);
            if (c % 37 == 0) begin
                dir = N'($urandom) & N'($urandom);
                inen = N'($urandom) | N'($urandom);
                edg = N'($urandom); both = N'($urandom); polar = N'($urandom);
                mska = N'($urandom); mskb = N'($urandom);
            end
            if (c % 11 == 0) pin = pin & 16'h00FF;
            tick(1);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule